// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count enable for a general-purpose timer and runs the timer's prescaler, main up counter and repetition counter from it. Everything runs on the single bus clock. The count source is either that bus clock, which gives an enable on every cycle, or one of several hardware trigger lines. A trigger line is first passed through a two-flop synchronizer. Then every rising edge of the selected line becomes a one-cycle pulse.

Two fields choose the source. A 3-bit mode field: the value 7 selects event counting, and every other value keeps the bus clock. A trigger select field: a nonzero value k picks trigger line k-1. The value 0 picks the software update strobe. In event mode with the software strobe selected, the strobe does not advance the count. It reloads the timer instead, as any software strobe does.

The prescaler divides its incoming enable by (prescaler value + 1). The counter runs from 0 up to the reload value and then wraps. The repetition counter holds back the update event until a set number of wraps has occurred. The prescaler value is held in a shadow register and takes effect only at an update event.

Top module: `tmr_clksel_top`

## Requirements
- R1: When the mode field is any value other than 7 (for example 0, 4, 5 or 6), the prescaler advances on every clock. After an update that loaded prescaler value P, `cnt_en` is high in cycles P, 2P+1, … counted from 0 at the first cycle after the update, so it is high once every P+1 cycles.
- R2: With mode 7 and trigger select k (1 ≤ k ≤ NUM_TRIG), the prescaler advances once per rising edge of `trig_in[k-1]`. With P = 0, `cnt_en` is high in exactly the second cycle after the cycle in which the line was first driven high.
- R3: A trigger line that stays high gives no further count, and a falling edge gives none.
- R4: In event mode, activity on trigger lines that are not selected does not count. A trigger select value above NUM_TRIG selects no line.
- R5: With mode 7 and trigger select 0, `cnt_en` stays low. A software strobe then sets the counter to 0 and does not increment it.
- R6: A software strobe `sw_upd` in any mode raises `upd_evt` in the same cycle. From the next cycle the counter is 0, the prescaler restarts using the current `psc_val`, and the repetition counter is reloaded with `rep_val`.
- R7: On each `cnt_en` the counter increments. When it equals `reload_val` it returns to 0.
- R8: An overflow raises `upd_evt` only when the repetition counter is 0, and that update reloads the repetition counter. With repetition value N and no strobe, an update therefore occurs on every (N+1)-th overflow.
- R9: A change on `psc_val` takes effect only at the next update event. Until then the running division ratio is kept.
- R10: `upd_evt` is never high unless `cnt_en` or `sw_upd` is high in the same cycle.
- R11: During and right after reset the counter reads 0. `upd_evt` is low while no strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | NUM_TRIG | Asynchronous hardware trigger lines |
| sw_upd | input | 1 | Single-cycle software update strobe |
| smode | input | 3 | Mode field; 7 selects event counting |
| tsel | input | $clog2(NUM_TRIG+1) | Trigger select; 0 is the software strobe, k selects trig_in[k-1] |
| psc_val | input | PSC_W | Prescaler value; divide ratio is value+1 |
| reload_val | input | CNT_W | Counter top value |
| rep_val | input | REP_W | Number of overflows to skip between updates |
| cnt_val | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter clock enable |
| upd_evt | output | 1 | Update-event pulse |

## Verification
In every bus-clock mode the prescaler is swept over several values. Each cycle's `cnt_en` is compared with the expected slot, which separates a wrong divide ratio from a wrong phase. Reload and repetition values are swept together, and the counter value and update pulse are compared on every cycle. This separates the wrap point from the repetition gating. The trigger tests pulse the selected line while the other lines toggle, hold it high for a long time, and select values that map to no line. These cases separate edge detection from level sensing and from mux leakage. A changed prescaler value before and after an update, and the strobe in the event-mode/software-source combination, confirm that a reload is not taken as a count.

// File: rtl/tclk_pkg.sv
// Shared constants and types for the timer clock source selector.
package tclk_pkg;
    localparam int SMODE_W = 3;
    // Mode value that switches the prescaler to trigger-edge counting.
    localparam logic [SMODE_W-1:0] SMODE_EVENT = 3'd7;

    // Which source feeds the prescaler tick.
    typedef enum logic [1:0] {
        TICK_BUS  = 2'd0,
        TICK_EDGE = 2'd1,
        TICK_OFF  = 2'd2
    } tick_src_e;
endpackage

// File: rtl/tclk_trig_edge.sv
// Synchronizes each hardware trigger line with two flops, selects one line
// and emits a one-cycle pulse per rising edge of the selected line.
// Assumes: tsel == k selects trig_in[k-1]; 0 or values above NUM_TRIG select
// nothing. tsel should change only while the selected levels are equal,
// otherwise the selection change itself can look like an edge.
module tclk_trig_edge #(
    parameter int NUM_TRIG = 4,
    parameter int TSEL_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [TSEL_W-1:0]   tsel,
    output logic                edge_pulse
);
    logic [NUM_TRIG-1:0] stab_lvl;
    logic                sel_lvl;
    logic                sel_prev;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_sync
        logic meta_q;
        logic stab_q;
        // Two-stage synchronizer for one trigger line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= trig_in[g];
                stab_q <= meta_q;
            end
        end
        assign stab_lvl[g] = stab_q;
    end

    // Select the synchronized level named by tsel.
    always_comb begin
        sel_lvl = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (tsel == TSEL_W'(i + 1)) begin
                sel_lvl = stab_lvl[i];
            end
        end
    end

    // Remember the last selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev <= 1'b0;
        end else begin
            sel_prev <= sel_lvl;
        end
    end

    assign edge_pulse = sel_lvl & ~sel_prev;
endmodule

// File: rtl/tclk_prescaler.sv
// Divides the incoming tick by (shadow value + 1) and gives one counter
// enable per terminal count. The divide value is taken from psc_val only
// when an update event occurs.
// Assumes: upd_now is high for the whole cycle of an update event.
module tclk_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             upd_now,
    input  logic [PSC_W-1:0] psc_val,
    output logic             cnt_en
);
    logic [PSC_W-1:0] psc_cnt;
    logic [PSC_W-1:0] psc_shadow;

    assign cnt_en = tick && (psc_cnt == psc_shadow);

    // Advance the divider; restart it and latch a new ratio on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_cnt    <= '0;
            psc_shadow <= '0;
        end else if (upd_now) begin
            psc_cnt    <= '0;
            psc_shadow <= psc_val;
        end else if (tick) begin
            psc_cnt <= cnt_en ? '0 : psc_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tclk_counter.sv
// Up counter that wraps at the reload value and a repetition down counter
// that lets an overflow through as an update only when it is at zero.
// Assumes: sw_upd is a single-cycle strobe; it has priority over counting.
module tclk_counter #(
    parameter int CNT_W = 8,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             sw_upd,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [REP_W-1:0] rep_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             hw_upd
);
    logic [REP_W-1:0] rep_cnt;
    logic             wrap;

    assign wrap   = cnt_en && (cnt_val == reload_val);
    assign hw_upd = wrap && (rep_cnt == '0);

    // Count, wrap at the reload value, and step the repetition counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_val <= '0;
            rep_cnt <= '0;
        end else if (sw_upd) begin
            cnt_val <= '0;
            rep_cnt <= rep_val;
        end else if (cnt_en) begin
            cnt_val <= wrap ? '0 : cnt_val + 1'b1;
            if (wrap) begin
                rep_cnt <= (rep_cnt == '0) ? rep_val : rep_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_clksel_top.sv
// Timer clock source selector: picks the bus clock or a trigger edge as the
// prescaler tick and runs prescaler, counter and repetition counter.
// Assumes: all inputs except trig_in are synchronous to clk; sw_upd is a
// single-cycle strobe and forces an update in every mode.
module tmr_clksel_top
    import tclk_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int REP_W    = 4,
    localparam int TSEL_W  = $clog2(NUM_TRIG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                sw_upd,
    input  logic [SMODE_W-1:0]  smode,
    input  logic [TSEL_W-1:0]   tsel,
    input  logic [PSC_W-1:0]    psc_val,
    input  logic [CNT_W-1:0]    reload_val,
    input  logic [REP_W-1:0]    rep_val,
    output logic [CNT_W-1:0]    cnt_val,
    output logic                cnt_en,
    output logic                upd_evt
);
    tick_src_e tick_src;
    logic      edge_pulse;
    logic      tick;
    logic      hw_upd;

    tclk_trig_edge #(
        .NUM_TRIG (NUM_TRIG),
        .TSEL_W   (TSEL_W)
    ) edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .tsel       (tsel),
        .edge_pulse (edge_pulse)
    );

    // Decode mode and trigger select into a tick source.
    always_comb begin
        if (smode != SMODE_EVENT) begin
            tick_src = TICK_BUS;
        end else if (tsel == '0) begin
            tick_src = TICK_OFF;
        end else begin
            tick_src = TICK_EDGE;
        end
    end

    // Form the prescaler tick from the chosen source.
    always_comb begin
        unique case (tick_src)
            TICK_BUS:  tick = 1'b1;
            TICK_EDGE: tick = edge_pulse;
            default:   tick = 1'b0;
        endcase
    end

    assign upd_evt = sw_upd | hw_upd;

    tclk_prescaler #(
        .PSC_W (PSC_W)
    ) psc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .upd_now (upd_evt),
        .psc_val (psc_val),
        .cnt_en  (cnt_en)
    );

    tclk_counter #(
        .CNT_W (CNT_W),
        .REP_W (REP_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .sw_upd     (sw_upd),
        .reload_val (reload_val),
        .rep_val    (rep_val),
        .cnt_val    (cnt_val),
        .hw_upd     (hw_upd)
    );
endmodule

// File: rtl/tclk_checker.sv
// Port-level properties of the timer clock source selector, bound to the top.
module tclk_checker #(
    parameter int CNT_W  = 8,
    parameter int TSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_upd,
    input logic [2:0]        smode,
    input logic [TSEL_W-1:0] tsel,
    input logic [CNT_W-1:0]  reload_val,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              cnt_en,
    input logic              upd_evt
);
    // R5: event mode with the software source never produces a count enable.
    a_r5_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (smode == 3'd7 && tsel == '0) |-> !cnt_en);

    // R6: a strobe raises the update pulse at once and clears the counter.
    a_r6_strobe_upd: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |-> upd_evt);
    a_r6_strobe_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |=> (cnt_val == '0));

    // R7: increment below the top, return to zero at the top, hold otherwise.
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !sw_upd && cnt_val != reload_val) |=> (cnt_val == $past(cnt_val) + 1'b1));
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !sw_upd && cnt_val == reload_val) |=> (cnt_val == '0));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !sw_upd) |=> $stable(cnt_val));

    // R8: a hardware update only happens at the top of the count.
    a_r8_upd_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !sw_upd) |-> (cnt_en && cnt_val == reload_val));

    // R10: no update without an enable or a strobe.
    a_r10_upd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> (cnt_en || sw_upd));
endmodule

bind tmr_clksel_top tclk_checker #(
    .CNT_W  (CNT_W),
    .TSEL_W (TSEL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_upd     (sw_upd),
    .smode      (smode),
    .tsel       (tsel),
    .reload_val (reload_val),
    .cnt_val    (cnt_val),
    .cnt_en     (cnt_en),
    .upd_evt    (upd_evt)
);

// File: tb/tmr_clksel_top_tb_top.sv
// Sweep-based bench: inputs change 1 time unit after the rising edge,
// outputs are sampled at the falling edge.
module tmr_clksel_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NT-1:0] trig_in;
    logic          sw_upd;
    logic [2:0]    smode;
    logic [TW-1:0] tsel;
    logic [7:0]    psc_val;
    logic [7:0]    reload_val;
    logic [3:0]    rep_val;
    logic [7:0]    cnt_val;
    logic          cnt_en;
    logic          upd_evt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_clksel_top #(
        .NUM_TRIG (NT),
        .PSC_W    (8),
        .CNT_W    (8),
        .REP_W    (4)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .sw_upd     (sw_upd),
        .smode      (smode),
        .tsel       (tsel),
        .psc_val    (psc_val),
        .reload_val (reload_val),
        .rep_val    (rep_val),
        .cnt_val    (cnt_val),
        .cnt_en     (cnt_en),
        .upd_evt    (upd_evt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    // R6: strobe for one cycle; upd_evt must be high in that same cycle.
    task automatic sw_strobe();
        sw_upd = 1'b1;
        @(negedge clk);
        check(upd_evt == 1'b1, "R6 strobe update", int'(upd_evt), 1);
        next_cycle();
        sw_upd = 1'b0;
    endtask

    // R1: divide ratio and phase in a bus-clock mode.
    task automatic period_test(input logic [2:0] m, input int p);
        int mism = 0;
        smode = m; tsel = '0; psc_val = 8'(p); reload_val = 8'd255; rep_val = 4'd0;
        sw_strobe();
        for (int c = 0; c < 4 * (p + 1); c++) begin
            @(negedge clk);
            if (cnt_en != ((c % (p + 1)) == p)) mism++;
            next_cycle();
        end
        @(negedge clk);
        check(mism == 0, "R1 enable slots", mism, 0);
        check(cnt_val == 8'd4, "R1 count after 4 periods", int'(cnt_val), 4);
        next_cycle();
    endtask

    // R7 R8 R10: wrap point and repetition gating, checked per cycle.
    task automatic wrap_test(input int r, input int n);
        int per = (n + 1) * (r + 1);
        int mc = 0;
        int mu = 0;
        smode = 3'd0; tsel = '0; psc_val = 8'd0; reload_val = 8'(r); rep_val = 4'(n);
        sw_strobe();
        for (int c = 0; c < 3 * per + 2; c++) begin
            @(negedge clk);
            if (cnt_val != 8'(c % (r + 1))) mc++;
            if (upd_evt != (((c + 1) % per) == 0)) mu++;
            next_cycle();
        end
        check(mc == 0, "R7 counter sequence", mc, 0);
        check(mu == 0, "R8 update slots (R10 no extra)", mu, 0);
    endtask

    int cnt0;
    int mism;
    int ens;

    initial begin
        rst_n = 1'b0; trig_in = '0; sw_upd = 1'b0; smode = 3'd7; tsel = 3'd1;
        psc_val = 8'd0; reload_val = 8'd255; rep_val = 4'd0;

        // R11: reset state.
        repeat (3) begin
            @(negedge clk);
            check(cnt_val == 8'd0, "R11 count in reset", int'(cnt_val), 0);
            check(upd_evt == 1'b0, "R11 no update in reset", int'(upd_evt), 0);
        end
        next_cycle();
        rst_n = 1'b1;
        repeat (3) next_cycle();
        @(negedge clk);
        check(cnt_val == 8'd0, "R11 count after reset", int'(cnt_val), 0);
        next_cycle();

        // R1: bus-clock modes with a prescaler sweep.
        foreach (smode_list[i]) begin
            for (int p = 0; p < 4; p++) period_test(smode_list[i], p);
        end

        // R7 R8: reload and repetition sweep.
        foreach (rl_list[i]) begin
            for (int n = 0; n < 3; n++) wrap_test(rl_list[i], n);
        end

        // R9: new prescaler value waits for the update event.
        smode = 3'd0; tsel = '0; psc_val = 8'd1; reload_val = 8'd3; rep_val = 4'd0;
        sw_strobe();
        psc_val = 8'd3;
        mism = 0; ens = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (c < 8) begin
                ens += int'(cnt_en);
                if (upd_evt != (c == 7)) mism++;
            end else begin
                if (cnt_en != ((c == 11) || (c == 15))) mism++;
            end
            next_cycle();
        end
        check(ens == 4, "R9 old ratio kept before update", ens, 4);
        check(mism == 0, "R9 new ratio after update", mism, 0);

        // R5: event mode with software source; strobe resets rather than counts.
        smode = 3'd0; tsel = '0; psc_val = 8'd0; reload_val = 8'd255; rep_val = 4'd0;
        sw_strobe();
        repeat (5) next_cycle();
        smode = 3'd7;
        ens = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            ens += int'(cnt_en);
            next_cycle();
        end
        check(ens == 0, "R5 no enable from software source", ens, 0);
        @(negedge clk);
        check(cnt_val == 8'd5, "R5 count held", int'(cnt_val), 5);
        next_cycle();
        sw_strobe();
        repeat (2) next_cycle();
        @(negedge clk);
        check(cnt_val == 8'd0, "R5 strobe reloads not increments", int'(cnt_val), 0);
        next_cycle();

        // R2 R3 R4: each trigger line with the others toggling.
        for (int k = 1; k <= NT; k++) begin
            trig_in = '0; tsel = TW'(k);
            repeat (3) next_cycle();
            sw_strobe();
            for (int p = 0; p < 3; p++) begin
                for (int c = 0; c < 6; c++) begin
                    trig_in = (c % 2 == 0) ? '1 : '0;
                    trig_in[k-1] = (c < 3);
                    next_cycle();
                end
            end
            trig_in = '0;
            repeat (4) next_cycle();
            @(negedge clk);
            check(cnt_val == 8'd3, "R2 one count per rising edge (R4 others ignored)", int'(cnt_val), 3);
            next_cycle();
            // R3: held high counts once, with the expected latency.
            trig_in[k-1] = 1'b1;
            mism = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (cnt_en != (c == 2)) mism++;
                next_cycle();
            end
            check(mism == 0, "R2 latency and R3 single pulse", mism, 0);
            trig_in = '0;
            repeat (6) next_cycle();
            @(negedge clk);
            check(cnt_val == 8'd4, "R3 no count on fall", int'(cnt_val), 4);
            next_cycle();
        end

        // R4: select values above the line count pick no line.
        for (int t = NT + 1; t < (1 << TW); t++) begin
            trig_in = '0; tsel = TW'(t);
            repeat (3) next_cycle();
            sw_strobe();
            ens = 0;
            for (int c = 0; c < 12; c++) begin
                trig_in = (c % 4 < 2) ? '1 : '0;
                @(negedge clk);
                ens += int'(cnt_en);
                next_cycle();
            end
            trig_in = '0;
            repeat (3) next_cycle();
            @(negedge clk);
            check(ens == 0 && cnt_val == 8'd0, "R4 unmapped select counts nothing", int'(cnt_val), 0);
            next_cycle();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    logic [2:0] smode_list [4] = '{3'd0, 3'd4, 3'd5, 3'd6};
    int         rl_list    [4] = '{0, 1, 2, 5};

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule